// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps the interrupt state of a packet network controller. An 8-bit status register collects pending causes and an 8-bit mask register selects which of them may raise a single level-sensitive interrupt line. Hardware event strobes set status bits. Two bits follow queue state: a transmit queue that is empty and a transmit-done queue that holds entries keep their bits set.

Software writes an acknowledge byte to clear causes. Only a fixed subset of bits can be cleared this way. When software acknowledges transmit completion, the block also sends a pop strobe to the transmit-done queue. A receive-queue pop event refreshes the receive bit. The queues, the packet memory and the bus decoder are outside this block. The block receives occupancy signals from them and returns only the pop strobe.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the status reads 0x04, the mask reads 0x00 and the interrupt output is low.
- R2: The event strobe `evt_set[i]` sets status bit i one clock later. The bit map is: 7 management, 6 early receive, 5 PHY event, 4 receive overrun, 3 allocation done, 2 transmit queue empty, 1 transmit complete, 0 receive.
- R3: `irq_o` is high exactly when `status_q & mask_q` is non-zero. It follows the registered values in the same cycle.
- R4: While `txq_empty` is high, status bit 2 is set at the next clock. A low `txq_empty` never clears that bit.
- R5: While `txdone_nonempty` is high, status bit 1 is set at the next clock, even if the same cycle acknowledges it.
- R6: An acknowledge write clears the status bits that are set in both `ack_data` and 0xD6. Bits 5, 3 and 0 are not changed by any acknowledge value.
- R7: `txdone_pop_o` is high in the cycle of an acknowledge write that has bit 1 set, provided `txdone_nonempty` is high. Otherwise it stays low, so an empty queue is never popped.
- R8: On `rx_pop`, status bit 0 is set at the next clock when `rx_remain` reports entries left, and cleared when none remain.
- R9: A set from any source wins over a clear of the same bit in the same cycle.
- R10: A mask write loads `mask_data` into the mask at the next clock and leaves the status unchanged. The status and mask outputs change only through the defined inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_set | input | 8 | One-cycle hardware set strobes, one per status bit |
| txq_empty | input | 1 | Transmit queue length is zero |
| txdone_nonempty | input | 1 | Transmit-done queue holds at least one entry |
| rx_pop | input | 1 | Receive queue was popped this cycle |
| rx_remain | input | 1 | Entries remain in the receive queue after the pop |
| ack_we | input | 1 | Acknowledge byte write strobe |
| ack_data | input | 8 | Acknowledge byte |
| mask_we | input | 1 | Mask byte write strobe |
| mask_data | input | 8 | Mask byte |
| status_q | output | 8 | Current interrupt status |
| mask_q | output | 8 | Current interrupt mask |
| irq_o | output | 1 | Level interrupt request |
| txdone_pop_o | output | 1 | Pop strobe to the transmit-done queue |

## Verification
The assertions assume that `txdone_nonempty` and `txq_empty` report the true queue state in the cycle they are sampled. They also assume that `rx_remain` has meaning only while `rx_pop` is high, and that strobes are single-cycle levels sampled at the clock edge. The bench drives every input on the falling edge and holds it for one full cycle. It keeps `rx_remain` low when no pop is signalled. It gives the queue flags stable values that a real queue could produce.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned B_MGMT     = 7;
  localparam int unsigned B_EARLY_RX = 6;
  localparam int unsigned B_PHY      = 5;
  localparam int unsigned B_RX_OVR   = 4;
  localparam int unsigned B_ALLOC    = 3;
  localparam int unsigned B_TX_EMPTY = 2;
  localparam int unsigned B_TX_DONE  = 1;
  localparam int unsigned B_RX       = 0;

  localparam logic [STAT_W-1:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [STAT_W-1:0] STATUS_RESET  = 8'h04;
  localparam logic [STAT_W-1:0] MASK_RESET    = 8'h00;

  // Bits that a given acknowledge byte is allowed to clear.
  function automatic logic [STAT_W-1:0] f_ack_clear(input logic [STAT_W-1:0] data);
    return data & ACK_CLEARABLE;
  endfunction

  // Level request from status and mask.
  function automatic logic f_pending(input logic [STAT_W-1:0] st,
                                     input logic [STAT_W-1:0] mk);
    return |(st & mk);
  endfunction

  // Vector with one bit placed at index idx when cond holds.
  function automatic logic [STAT_W-1:0] f_bit_at(input logic cond, input int unsigned idx);
    logic [STAT_W-1:0] v;
    v = '0;
    v[idx] = cond;
    return v;
  endfunction
endpackage

// File: rtl/irq_event_merge.sv
module irq_event_merge
  import irq_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic [W-1:0] evt_set,
  input  logic         txq_empty,
  input  logic         txdone_nonempty,
  input  logic         rx_pop,
  input  logic         rx_remain,
  output logic [W-1:0] set_vec,
  output logic [W-1:0] rx_clr_vec
);
  logic [W-1:0] level_vec;
  logic [W-1:0] rx_set_vec;

  always_comb begin
    level_vec  = f_bit_at(txq_empty, B_TX_EMPTY) | f_bit_at(txdone_nonempty, B_TX_DONE);
    rx_set_vec = f_bit_at(rx_pop && rx_remain, B_RX);
    rx_clr_vec = f_bit_at(rx_pop && !rx_remain, B_RX);
    set_vec    = evt_set | level_vec | rx_set_vec;
  end
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode
  import irq_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  input  logic         txdone_nonempty,
  output logic [W-1:0] ack_clr_vec,
  output logic         pop_o
);
  always_comb begin
    ack_clr_vec = ack_we ? f_ack_clear(ack_data) : '0;
    pop_o       = ack_we && ack_data[B_TX_DONE] && txdone_nonempty;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
#(
  parameter int unsigned   W         = STAT_W,
  parameter logic [W-1:0]  RESET_VAL = STATUS_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[i] <= RESET_VAL[i];
      else if (set_vec[i]) q[i] <= 1'b1;
      else if (clr_vec[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out
  import irq_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  input  logic [W-1:0] status,
  output logic [W-1:0] mask_q,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RESET;
    else if (mask_we) mask_q <= mask_data;
  end

  assign irq_o = f_pending(status, mask_q);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_set,
  input  logic         txq_empty,
  input  logic         txdone_nonempty,
  input  logic         rx_pop,
  input  logic         rx_remain,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q,
  output logic         irq_o,
  output logic         txdone_pop_o
);
  // Named internal events, visible to the bound checker.
  logic [W-1:0] set_vec;
  logic [W-1:0] rx_clr_vec;
  logic [W-1:0] ack_clr_vec;
  logic [W-1:0] clr_vec;

  irq_event_merge #(.W(W)) u_merge (
    .evt_set         (evt_set),
    .txq_empty       (txq_empty),
    .txdone_nonempty (txdone_nonempty),
    .rx_pop          (rx_pop),
    .rx_remain       (rx_remain),
    .set_vec         (set_vec),
    .rx_clr_vec      (rx_clr_vec)
  );

  irq_ack_decode #(.W(W)) u_ack (
    .ack_we          (ack_we),
    .ack_data        (ack_data),
    .txdone_nonempty (txdone_nonempty),
    .ack_clr_vec     (ack_clr_vec),
    .pop_o           (txdone_pop_o)
  );

  assign clr_vec = ack_clr_vec | rx_clr_vec;

  irq_status_reg #(.W(W), .RESET_VAL(STATUS_RESET)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (status_q)
  );

  irq_mask_out #(.W(W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (mask_we),
    .mask_data (mask_data),
    .status    (status_q),
    .mask_q    (mask_q),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt_set,
  input logic         txq_empty,
  input logic         txdone_nonempty,
  input logic         rx_pop,
  input logic         rx_remain,
  input logic         ack_we,
  input logic [W-1:0] ack_data,
  input logic         mask_we,
  input logic [W-1:0] mask_data,
  input logic [W-1:0] status_q,
  input logic [W-1:0] mask_q,
  input logic         irq_o,
  input logic         txdone_pop_o
);
  a_r3_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_q & mask_q) != '0));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set[B_MGMT] |=> status_q[B_MGMT]);

  a_r4_tx_empty_forced: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |=> status_q[B_TX_EMPTY]);

  a_r5_tx_done_forced: assert property (@(posedge clk) disable iff (!rst_n)
    txdone_nonempty |=> status_q[B_TX_DONE]);

  a_r6_phy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[B_PHY] |=> status_q[B_PHY]);

  a_r6_alloc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[B_ALLOC] |=> status_q[B_ALLOC]);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_data[B_MGMT] && !evt_set[B_MGMT]) |=> !status_q[B_MGMT]);

  a_r7_pop_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    txdone_pop_o |-> (ack_we && ack_data[B_TX_DONE] && txdone_nonempty));

  a_r8_rx_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_remain && !evt_set[B_RX]) |=> !status_q[B_RX]);

  a_r9_set_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set[B_RX_OVR] && ack_we && ack_data[B_RX_OVR]) |=> status_q[B_RX_OVR]);

  a_r10_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_data)));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_set = '0;
  logic       txq_empty = 1'b0;
  logic       txdone_nonempty = 1'b0;
  logic       rx_pop = 1'b0;
  logic       rx_remain = 1'b0;
  logic       ack_we = 1'b0;
  logic [7:0] ack_data = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_data = '0;
  logic [7:0] status_q;
  logic [7:0] mask_q;
  logic       irq_o;
  logic       txdone_pop_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] st;
    logic [7:0] mk;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  logic [7:0] m_st;
  logic [7:0] m_mk;

  always #2.5 clk = ~clk;

  irq_status_ctrl dut (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare registered results one step after the edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(status_q == e.st, e.tag, "status", status_q, e.st);
      check(mask_q == e.mk, e.tag, "mask", mask_q, e.mk);
      check(irq_o == e.irq, e.tag, "irq", {7'd0, irq_o}, {7'd0, e.irq});
    end
  end

  // Driver: apply one cycle of stimulus, predict and push the result.
  task automatic step(input logic [7:0] ev, input logic te, input logic td,
                      input logic rp, input logic rr,
                      input logic aw, input logic [7:0] ad,
                      input logic mw, input logic [7:0] md,
                      input string tag);
    logic [7:0] nx;
    logic       exp_pop;
    exp_t       e;
    @(negedge clk);
    evt_set = ev; txq_empty = te; txdone_nonempty = td;
    rx_pop = rp; rx_remain = rr; ack_we = aw; ack_data = ad;
    mask_we = mw; mask_data = md;
    // Prediction written bit by bit: set sources first, then clears.
    for (int b = 0; b < 8; b++) begin
      logic s, c;
      s = ev[b] || (b == 2 && te) || (b == 1 && td) || (b == 0 && rp && rr);
      c = (aw && ad[b] && (b == 7 || b == 6 || b == 4 || b == 2 || b == 1))
          || (b == 0 && rp && !rr);
      nx[b] = s ? 1'b1 : (c ? 1'b0 : m_st[b]);
    end
    m_st = nx;
    if (mw) m_mk = md;
    e.st = m_st; e.mk = m_mk; e.irq = ((m_st & m_mk) != 8'h00); e.tag = tag;
    sb_q.push_back(e);
    exp_pop = aw && ad[1] && td;
    #0.5;
    check(txdone_pop_o == exp_pop, "R7", "pop", {7'd0, txdone_pop_o}, {7'd0, exp_pop});
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_st = 8'h04; m_mk = 8'h00;
    repeat (3) @(negedge clk);
    check(status_q == 8'h04, "R1", "reset status", status_q, 8'h04);
    check(mask_q == 8'h00, "R1", "reset mask", mask_q, 8'h00);
    check(irq_o == 1'b0, "R1", "reset irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R1");
    // R4: low txq_empty keeps bit 2
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R4");
    // R10/R3: mask write, irq follows
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 1, 8'hFF, "R10");
    // R6: clear bit 2 by ack
    step(8'h00, 0, 0, 0, 0, 1, 8'h04, 0, 8'h00, "R6");
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R3");
    // R2: each event strobe
    step(8'h80, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R2");
    step(8'h68, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R2");
    step(8'h11, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R2");
    // R6: full ack leaves 5, 3, 0
    step(8'h00, 0, 0, 0, 0, 1, 8'hFF, 0, 8'h00, "R6");
    step(8'h00, 0, 0, 0, 0, 1, 8'h29, 0, 8'h00, "R6");
    // R3: mask only a cleared bit -> irq low
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 1, 8'h80, "R3");
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 1, 8'h20, "R3");
    // R5/R7: transmit done, ack while queue nonempty
    step(8'h00, 0, 1, 0, 0, 0, 8'h00, 1, 8'h02, "R5");
    step(8'h00, 0, 1, 0, 0, 1, 8'h02, 0, 8'h00, "R5");
    step(8'h00, 0, 0, 0, 0, 1, 8'h02, 0, 8'h00, "R7");
    step(8'h00, 0, 0, 0, 0, 1, 8'h02, 0, 8'h00, "R7");
    // R4: txq_empty sets, ack same cycle cannot clear
    step(8'h00, 1, 0, 0, 0, 1, 8'h04, 1, 8'h04, "R4");
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R4");
    // R8: receive pops
    step(8'h00, 0, 0, 1, 1, 0, 8'h00, 1, 8'h01, "R8");
    step(8'h00, 0, 0, 1, 0, 0, 8'h00, 0, 8'h00, "R8");
    step(8'h00, 0, 0, 1, 1, 0, 8'h00, 0, 8'h00, "R8");
    step(8'h00, 0, 0, 1, 0, 0, 8'h00, 0, 8'h00, "R8");
    // R9: set wins over ack and over rx drain
    step(8'h10, 0, 0, 0, 0, 1, 8'h10, 1, 8'h10, "R9");
    step(8'h01, 0, 0, 1, 0, 0, 8'h00, 0, 8'h00, "R9");
    step(8'h40, 0, 1, 0, 0, 1, 8'hC2, 0, 8'h00, "R9");
    // R10: idle cycles change nothing
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R10");
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule